// File: doc/BRIEF.md
# Adaptive Per-Row Refresh Rate Controller

This block chooses, one DRAM row at a time, how often that row gets refreshed. It keeps one rate bit per row. A row whose bit is set is refreshed in every refresh round. A row whose bit is clear is refreshed only in every `SLOW_MULT`-th round. With the default multiple of 4 and a 64 ms round, clear rows see a 256 ms interval. A separate scrub pass runs on its own timer. It asks the memory side to read every row through the ECC path. Any ECC error reported back for a row sets that row's bit, so the row stays on the fast rate for good.

Software or a boot sequence loads the table in one shot from a retention profile, using a full-width write. After that the table only gains set bits, one for each row that shows an ECC error. Refresh and scrub requests leave the block on two valid/ready channels that carry a row index. The refresh channel always goes first. The round period and the scrub period are given in clock cycles, so a simulation can shrink 64 ms and 15 minutes to a few hundred cycles.

Top module: `adaptive_refresh_ctl`

## Requirements
- R1: While reset is held and right after it, every rate bit is 1 (fast), `fast_count` equals `ROWS`, and neither `ref_valid` nor `scr_valid` is asserted.
- R2: A cycle with `prof_we` high replaces the whole table with `prof_bits`. Bit i is the rate of row i, where 1 means fast and 0 means slow. The new table is visible on the next cycle.
- R3: Every `ROUND_CYC` cycles a refresh round begins. It visits rows 0 to `ROWS-1` in ascending order and offers one refresh request for each row that it must refresh in that round.
- R4: Rounds are numbered from 0 starting at reset. In a round whose number modulo `SLOW_MULT` is 0, every row is refreshed. In any other round, only rows with their bit at 1 are refreshed.
- R5: Once `ref_valid` is high it stays high, with `ref_row` unchanged, until `ref_ready` accepts it. The one exception is a profile load that clears that row's bit.
- R6: Every `SCRUB_CYC` cycles a scrub pass begins. It issues exactly one scrub read for each row, in ascending order from row 0. `scr_row` holds steady while the request waits for `scr_ready`.
- R7: A cycle with `ecc_err` high sets the bit of row `ecc_row` to 1 from the next cycle on.
- R8: When `prof_we` is low, no rate bit ever goes from 1 to 0.
- R9: When `prof_we` and `ecc_err` arrive in the same cycle, the loaded table is taken, except that the bit of `ecc_row` ends up 1.
- R10: `scr_valid` is never high in a cycle where `ref_valid` is high. A scrub pass that is in progress waits until the refresh request is accepted.
- R11: `fast_count` always equals the number of rate bits currently set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prof_we | input | 1 | Load the whole rate table from `prof_bits` |
| prof_bits | input | ROWS | Profile result, bit i = 1 puts row i on the fast rate |
| ecc_err | input | 1 | A scrub read reported an ECC-corrected error |
| ecc_row | input | $clog2(ROWS) | Row that the ECC error belongs to |
| ref_valid | output | 1 | Refresh request pending |
| ref_ready | input | 1 | Refresh request accepted |
| ref_row | output | $clog2(ROWS) | Row to refresh |
| scr_valid | output | 1 | Scrub read request pending |
| scr_ready | input | 1 | Scrub read accepted |
| scr_row | output | $clog2(ROWS) | Row to scrub |
| fast_count | output | $clog2(ROWS+1) | Number of rows on the fast rate |

## Verification
The assertions assume that `ecc_row` always names an existing row. They also assume that a profile load lowering a row's bit is the only event allowed to withdraw a pending refresh. The stimulus uses eight rows and reports ECC errors only for rows that the scrub pass has just read. Profile loads happen only in gaps between rounds, plus one load made on purpose in the same cycle as an injected error. The timers are set so that refresh rounds and scrub passes stay apart, except in one planned overlap. In that overlap the refresh channel is stalled while a scrub pass becomes due, which tests the priority and the hold rules.

// File: rtl/adaptive_refresh_ctl.sv
module adaptive_refresh_ctl #(
  parameter int ROWS      = 64,
  parameter int SLOW_MULT = 4,
  parameter int ROUND_CYC = 3200000,
  parameter int SCRUB_CYC = 1000000000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      prof_we,
  input  logic [ROWS-1:0]           prof_bits,
  input  logic                      ecc_err,
  input  logic [$clog2(ROWS)-1:0]   ecc_row,
  output logic                      ref_valid,
  input  logic                      ref_ready,
  output logic [$clog2(ROWS)-1:0]   ref_row,
  output logic                      scr_valid,
  input  logic                      scr_ready,
  output logic [$clog2(ROWS)-1:0]   scr_row,
  output logic [$clog2(ROWS+1)-1:0] fast_count
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(ROWS + 1);
  localparam int TW = $clog2(ROUND_CYC);
  localparam int SW = $clog2(SCRUB_CYC);
  localparam int MW = (SLOW_MULT > 1) ? $clog2(SLOW_MULT) : 1;

  logic [ROWS-1:0] fast, fast_d;
  logic [TW-1:0]   rtmr;
  logic [SW-1:0]   stmr;
  logic            rtick, stick, rpend, spend;
  logic            in_round, in_scrub;
  logic [RW-1:0]   rptr, sptr;
  logic [MW-1:0]   ridx;
  logic            need, radv, sadv, rstart, sstart;
  logic [CW-1:0]   cnt;

  // period timers
  assign rtick = rtmr == TW'(ROUND_CYC - 1);
  assign stick = stmr == SW'(SCRUB_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rtmr <= '0;
      stmr <= '0;
    end else begin
      rtmr <= rtick ? '0 : rtmr + 1'b1;
      stmr <= stick ? '0 : stmr + 1'b1;
    end
  end

  assign rstart = rpend && !in_round;
  assign sstart = spend && !in_scrub;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpend <= 1'b0;
      spend <= 1'b0;
    end else begin
      if (rstart) rpend <= 1'b0;
      if (rtick)  rpend <= 1'b1;
      if (sstart) spend <= 1'b0;
      if (stick)  spend <= 1'b1;
    end
  end

  // refresh round walker
  assign need      = fast[rptr] || (ridx == '0);
  assign ref_valid = in_round && need;
  assign ref_row   = rptr;
  assign radv      = in_round && (!need || ref_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_round <= 1'b0;
      rptr     <= '0;
      ridx     <= '0;
    end else if (rstart) begin
      in_round <= 1'b1;
      rptr     <= '0;
    end else if (radv) begin
      if (rptr == RW'(ROWS - 1)) begin
        in_round <= 1'b0;
        ridx     <= (ridx == MW'(SLOW_MULT - 1)) ? '0 : ridx + 1'b1;
      end else begin
        rptr <= rptr + 1'b1;
      end
    end
  end

  // scrub walker, yields to refresh
  assign scr_valid = in_scrub && !ref_valid;
  assign scr_row   = sptr;
  assign sadv      = scr_valid && scr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_scrub <= 1'b0;
      sptr     <= '0;
    end else if (sstart) begin
      in_scrub <= 1'b1;
      sptr     <= '0;
    end else if (sadv) begin
      if (sptr == RW'(ROWS - 1)) in_scrub <= 1'b0;
      else                       sptr     <= sptr + 1'b1;
    end
  end

  // rate table: load overwrites, ECC error upgrades and wins
  always_comb begin
    fast_d = prof_we ? prof_bits : fast;
    if (ecc_err && (int'(ecc_row) < ROWS)) fast_d[ecc_row] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fast <= '1;
    else        fast <= fast_d;
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < ROWS; i++) cnt = cnt + CW'(fast[i]);
  end
  assign fast_count = cnt;

  p_ref_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && !ref_ready && !prof_we |=> ref_valid && $stable(ref_row));

  p_scr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scr_valid && !scr_ready && !prof_we |=> $stable(scr_row));

  p_ecc_upgrade_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_err |=> fast[$past(ecc_row)]);

  p_no_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !prof_we |=> ((fast & $past(fast)) == $past(fast)));

  p_upgrade_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prof_we && ecc_err |=> fast[$past(ecc_row)]);

  p_ref_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |-> !scr_valid);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prof_we && !ecc_err |=> fast == $past(prof_bits));
endmodule

// File: tb/test_adaptive_refresh_ctl.sv
module test_adaptive_refresh_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NR   = 8;
  localparam int MULT = 4;
  localparam int RCYC = 100;
  localparam int SCYC = 370;
  localparam int WDOG = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prof_we = 1'b0;
  logic [7:0] prof_bits = '0;
  logic       ecc_err = 1'b0;
  logic [2:0] ecc_row = '0;
  logic       ref_valid, ref_ready = 1'b1, scr_valid, scr_ready = 1'b1;
  logic [2:0] ref_row, scr_row;
  logic [3:0] fast_count;

  adaptive_refresh_ctl #(.ROWS(NR), .SLOW_MULT(MULT), .ROUND_CYC(RCYC), .SCRUB_CYC(SCYC))
    i_adaptive_refresh_ctl (.clk(clk), .rst_n(rst_n), .prof_we(prof_we), .prof_bits(prof_bits),
      .ecc_err(ecc_err), .ecc_row(ecc_row), .ref_valid(ref_valid), .ref_ready(ref_ready),
      .ref_row(ref_row), .scr_valid(scr_valid), .scr_ready(scr_ready), .scr_row(scr_row),
      .fast_count(fast_count));

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int exp_q[$];
  logic [7:0] mflag = 8'hFF;
  logic [7:0] wmask = '0;
  int sexp = 0, scnt = 0;
  logic npend = 1'b0;
  logic [2:0] nrow = '0;
  int inj_cyc = -1;
  logic [2:0] inj_row = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard driver: expected refreshes for the next round
  task automatic push_round(input int k);
    chk(exp_q.size() == 0, "R3 previous round incomplete", exp_q.size(), 0);
    for (int r = 0; r < NR; r++)
      if (mflag[r] || (k % MULT) == 0) exp_q.push_back(r);
  endtask

  task automatic tick();
    // monitor: handshakes that complete at the coming edge
    if (ref_valid && ref_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected refresh", int'(ref_row), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(ref_row) == e, "R3 R4 refresh row", int'(ref_row), e);
      end
    end
    if (ref_valid && scr_valid) chk(1'b0, "R10 both requests valid", 1, 0);
    if (scr_valid && scr_ready) begin
      chk(int'(scr_row) == sexp, "R6 scrub row order", int'(scr_row), sexp);
      sexp  = (sexp + 1) % NR;
      scnt++;
      npend = wmask[scr_row];
      nrow  = scr_row;
    end else npend = 1'b0;
    @(negedge clk);
    cyc++;
    ecc_err = 1'b0;
    if (npend) begin ecc_err = 1'b1; ecc_row = nrow; end
    else if (cyc == inj_cyc) begin ecc_err = 1'b1; ecc_row = inj_row; end
    if (cyc % RCYC == RCYC - 10) push_round(cyc / RCYC);
    if (cyc >= WDOG) begin
      chk(1'b0, "watchdog", cyc, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) tick();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(fast_count == 4'd8, "R1 fast_count in reset", fast_count, 8);
    rst_n = 1'b1;
    chk(!ref_valid, "R1 ref_valid after reset", ref_valid, 0);
    chk(!scr_valid, "R1 scr_valid after reset", scr_valid, 0);

    wait_cyc(20);
    prof_we = 1'b1; prof_bits = 8'b0000_0101;
    tick();
    prof_we = 1'b0;
    mflag = 8'b0000_0101;
    tick();
    chk(fast_count == 4'd2, "R2 R11 count after profile load", fast_count, 2);
    wmask = 8'b0010_0000;

    wait_cyc(385);
    chk(scnt == NR, "R6 first scrub pass length", scnt, NR);
    mflag[5] = 1'b1;
    chk(fast_count == 4'd3, "R7 row 5 upgraded", fast_count, 3);
    wmask = 8'b1010_0000;

    wait_cyc(450);
    chk(fast_count == 4'd3, "R8 no bit cleared", fast_count, 3);

    wait_cyc(760);
    mflag[7] = 1'b1;
    chk(fast_count == 4'd4, "R7 row 7 upgraded", fast_count, 4);
    inj_cyc = 770; inj_row = 3'd6;
    wait_cyc(770);
    prof_we = 1'b1; prof_bits = 8'b0000_0001;
    tick();
    prof_we = 1'b0;
    mflag = 8'b0100_0001;
    wait_cyc(780);
    chk(fast_count == 4'd2, "R9 upgrade wins over load", fast_count, 2);
    chk(scnt == 2*NR, "R6 second scrub pass length", scnt, 2*NR);
    wmask = '0;

    wait_cyc(1095);
    ref_ready = 1'b0;
    wait_cyc(1120);
    chk(ref_valid, "R5 refresh held under stall", ref_valid, 1);
    chk(ref_row == 3'd0, "R5 stalled row", ref_row, 0);
    chk(!scr_valid, "R10 scrub waits for refresh", scr_valid, 0);
    wait_cyc(1125);
    chk(ref_valid && ref_row == 3'd0, "R5 row stable", ref_row, 0);
    ref_ready = 1'b1;

    wait_cyc(1180);
    chk(exp_q.size() == 0, "R3 last round complete", exp_q.size(), 0);
    chk(scnt == 3*NR, "R6 R10 deferred scrub pass done", scnt, 3*NR);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule